// File: doc/BRIEF.md
# Prioritized Local-to-PCI Address Window Translator

This block sits on the local-bus side of a host-to-PCI bridge. It turns a local-bus address into a PCI address by way of three programmable windows. Each window is a pair of registers. The base word says which local range the window covers. The map word says where that range lands on PCI and what kind of PCI cycle it produces. A simple register-write port programs the six words.

The lookup is purely combinational. For any local address it reports whether a window hit, which window it was, the translated PCI address, the cycle type, the prefetchable attribute and whether the two lowest address bits go through. Windows may overlap on purpose, and the lowest-numbered enabled window always wins. Software uses this to reach configuration space:

- It enlarges window 0 so that it covers the range window 1 normally serves.
- It points window 1 at configuration space and uses it there.
- It then restores window 1 and shrinks window 0 again.

Top module: `addr_window_xlate`

## Requirements
- R1: After reset every register is zero, so no window is enabled and every lookup misses.
- R2: A write happens on a rising clock edge while `wrEn` is 1. `wrSel` picks the word: 0 base0, 1 map0, 2 base1, 3 map1, 4 base2, 5 map2. Map words and the window-2 base take `wrData[15:0]`. Select codes 6 and 7, and any cycle with `wrEn` at 0, change nothing.
- R3: In the 32-bit base word of window 0 or 1, bit 0 enables the window and bits 31:20 give the local base. Bits 7:4 are a size code c, giving a size of 1 MB shifted left by c (c=8 is 256 MB, c=11 is 2 GB). Bit 3 is reported as `prefetch` on a hit.
- R4: A window 0/1 size code of 12 to 15 disables that window.
- R5: For a window 0/1 of size 2^n, a hit needs local address bits 31:n to equal base bits 31:n. The PCI address takes bits 31:n from map bits 15:4 (as PCI bits 31:20) and bits n-1:0 from the local address.
- R6: In the window 0/1 map word, bits 3:1 are the cycle type and appear on `cycType` (000 interrupt acknowledge, 001 I/O, 011 memory, 101 configuration, 110 memory-multiple). Bit 0 is the low-bit enable and appears on `lowAdEn`. When it is 0, `pciAddr[1:0]` is 00. When it is 1, those bits pass through from the local address.
- R7: Window 2 is a fixed 16 MB I/O window, enabled by base2 bit 0, and it hits when local bits 31:24 equal base2 bits 15:8. Its PCI address is map2 bits 15:8 followed by local bits 23:0. It reports `cycType` 001, `prefetch` 0 and `lowAdEn` 1.
- R8: When several enabled windows contain the address, window 0 beats window 1 and window 1 beats window 2. `winIdx` gives the selected window number.
- R9: On a miss, `hit`, `winIdx`, `pciAddr`, `cycType`, `prefetch` and `lowAdEn` are all zero.
- R10: The lookup follows `lookAddr` in the same cycle. A register write changes lookups only after the clock edge that performs it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 3 | Register select for the write |
| wrData | input | 32 | Write data |
| lookAddr | input | 32 | Local-bus address to translate |
| hit | output | 1 | An enabled window contains the address |
| winIdx | output | 2 | Number of the selected window |
| pciAddr | output | 32 | Translated PCI address |
| cycType | output | 3 | PCI cycle type of the selected window |
| prefetch | output | 1 | Selected window is prefetchable |
| lowAdEn | output | 1 | Low address bits are passed to PCI |

## Verification
The checker watches several rules on every cycle:

- A miss drives all-zero outputs.
- With `lowAdEn` low, the two lowest PCI bits are zero.
- Window 0/1 hits keep local bits 19:2.
- Window-2 hits carry local bits 23:0, cycle type I/O and no prefetch.
- No hit occurs before any register has been written.

Other behaviour only the directed scenarios can show, because it depends on programmed contents:

- Which window wins when windows overlap.
- The exact boundary each size code gives.
- Disabling by oversized codes.
- Rejection of unused select codes.
- The cycle in which a write takes effect.
- The enlarge-and-remap sequence used to reach configuration space.

// File: rtl/awx_pkg.sv
package awx_pkg;
  localparam int ADDR_W     = 32;
  localparam int WIDE_WINS  = 2;
  localparam int NUM_WINS   = WIDE_WINS + 1;
  localparam int SEL_W      = 3;
  localparam int MAP_W      = 16;
  localparam int MIN_SHIFT  = 20;
  localparam int MAX_CODE   = 11;
  localparam int IO_SHIFT   = 24;

  localparam logic [2:0] CYC_IO = 3'b001;

  typedef struct packed {
    logic [NUM_WINS-1:0] baseWr;
    logic [NUM_WINS-1:0] mapWr;
    logic [ADDR_W-1:0]   data;
  } awxStrobes_t;
endpackage

// File: rtl/awx_ctrl.sv
module awx_ctrl
  import awx_pkg::*;
(
  input  logic              wrEn,
  input  logic [SEL_W-1:0]  wrSel,
  input  logic [ADDR_W-1:0] wrData,
  output awxStrobes_t       strobes
);
  always_comb begin
    strobes.baseWr = '0;
    strobes.mapWr  = '0;
    strobes.data   = wrData;
    if (wrEn) begin
      for (int w = 0; w < NUM_WINS; w++) begin
        if (wrSel == SEL_W'(2 * w))     strobes.baseWr[w] = 1'b1;
        if (wrSel == SEL_W'(2 * w + 1)) strobes.mapWr[w]  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/awx_win_wide.sv
module awx_win_wide
  import awx_pkg::*;
(
  input  logic [ADDR_W-1:0] baseWord,
  input  logic [MAP_W-1:0]  mapWord,
  input  logic [ADDR_W-1:0] addr,
  output logic              winHit,
  output logic [ADDR_W-1:0] xAddr,
  output logic [2:0]        winType,
  output logic              winPref,
  output logic              winLowEn
);
  localparam int SHIFT_W = $clog2(ADDR_W);

  logic [3:0]        sizeCode;
  logic              codeOk;
  logic [SHIFT_W-1:0] winShift;
  logic [ADDR_W-1:0] keepMask;
  logic [ADDR_W-1:0] mapBase;
  logic              unusedBits;

  assign sizeCode = baseWord[7:4];
  assign codeOk   = (sizeCode <= 4'(MAX_CODE));
  assign winShift = SHIFT_W'(MIN_SHIFT) + SHIFT_W'(sizeCode);
  assign keepMask = codeOk ? ({ADDR_W{1'b1}} << winShift) : '0;
  assign mapBase  = {mapWord[MAP_W-1:4], {MIN_SHIFT{1'b0}}};

  assign winHit   = baseWord[0] && codeOk &&
                    (((addr ^ baseWord) & keepMask) == '0);
  assign xAddr    = (mapBase & keepMask) | (addr & ~keepMask);
  assign winType  = mapWord[3:1];
  assign winPref  = baseWord[3];
  assign winLowEn = mapWord[0];

  assign unusedBits = ^{baseWord[MIN_SHIFT-1:8], baseWord[2:1]};
endmodule

// File: rtl/awx_dp.sv
module awx_dp
  import awx_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  awxStrobes_t       strobes,
  input  logic [ADDR_W-1:0] lookAddr,
  output logic              hit,
  output logic [1:0]        winIdx,
  output logic [ADDR_W-1:0] pciAddr,
  output logic [2:0]        cycType,
  output logic              prefetch,
  output logic              lowAdEn
);
  logic [ADDR_W-1:0] baseReg [WIDE_WINS];
  logic [MAP_W-1:0]  mapReg  [WIDE_WINS];
  logic [MAP_W-1:0]  ioBaseReg;
  logic [MAP_W-1:0]  ioMapReg;

  logic [WIDE_WINS-1:0] wHit;
  logic [ADDR_W-1:0]    wAddr [WIDE_WINS];
  logic [2:0]           wType [WIDE_WINS];
  logic [WIDE_WINS-1:0] wPref;
  logic [WIDE_WINS-1:0] wLowEn;

  logic              ioHit;
  logic [ADDR_W-1:0] ioAddr;
  logic              unusedIo;

  genvar gi;
  generate
    for (gi = 0; gi < WIDE_WINS; gi++) begin : g_wide
      always_ff @(posedge clk) begin
        if (!rstN) begin
          baseReg[gi] <= '0;
          mapReg[gi]  <= '0;
        end else begin
          if (strobes.baseWr[gi]) baseReg[gi] <= strobes.data;
          if (strobes.mapWr[gi])  mapReg[gi]  <= strobes.data[MAP_W-1:0];
        end
      end

      awx_win_wide u_win (
        .baseWord (baseReg[gi]),
        .mapWord  (mapReg[gi]),
        .addr     (lookAddr),
        .winHit   (wHit[gi]),
        .xAddr    (wAddr[gi]),
        .winType  (wType[gi]),
        .winPref  (wPref[gi]),
        .winLowEn (wLowEn[gi])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ioBaseReg <= '0;
      ioMapReg  <= '0;
    end else begin
      if (strobes.baseWr[WIDE_WINS]) ioBaseReg <= strobes.data[MAP_W-1:0];
      if (strobes.mapWr[WIDE_WINS])  ioMapReg  <= strobes.data[MAP_W-1:0];
    end
  end

  assign ioHit  = ioBaseReg[0] &&
                  (lookAddr[ADDR_W-1:IO_SHIFT] == ioBaseReg[MAP_W-1:8]);
  assign ioAddr = {ioMapReg[MAP_W-1:8], lookAddr[IO_SHIFT-1:0]};
  assign unusedIo = ^{ioBaseReg[7:1], ioMapReg[7:0],
                      strobes.data[ADDR_W-1:MAP_W]};

  always_comb begin
    hit      = 1'b0;
    winIdx   = '0;
    pciAddr  = '0;
    cycType  = '0;
    prefetch = 1'b0;
    lowAdEn  = 1'b0;
    for (int w = WIDE_WINS - 1; w >= 0; w--) begin
      if (wHit[w]) begin
        hit      = 1'b1;
        winIdx   = 2'(w);
        pciAddr  = wLowEn[w] ? wAddr[w] : {wAddr[w][ADDR_W-1:2], 2'b00};
        cycType  = wType[w];
        prefetch = wPref[w];
        lowAdEn  = wLowEn[w];
      end
    end
    if (!hit && ioHit) begin
      hit      = 1'b1;
      winIdx   = 2'(WIDE_WINS);
      pciAddr  = ioAddr;
      cycType  = CYC_IO;
      prefetch = 1'b0;
      lowAdEn  = 1'b1;
    end
  end
endmodule

// File: rtl/addr_window_xlate.sv
module addr_window_xlate
  import awx_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [SEL_W-1:0]  wrSel,
  input  logic [ADDR_W-1:0] wrData,
  input  logic [ADDR_W-1:0] lookAddr,
  output logic              hit,
  output logic [1:0]        winIdx,
  output logic [ADDR_W-1:0] pciAddr,
  output logic [2:0]        cycType,
  output logic              prefetch,
  output logic              lowAdEn
);
  awxStrobes_t strobes;

  awx_ctrl u_ctrl (
    .wrEn    (wrEn),
    .wrSel   (wrSel),
    .wrData  (wrData),
    .strobes (strobes)
  );

  awx_dp u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .lookAddr (lookAddr),
    .hit      (hit),
    .winIdx   (winIdx),
    .pciAddr  (pciAddr),
    .cycType  (cycType),
    .prefetch (prefetch),
    .lowAdEn  (lowAdEn)
  );
endmodule

// File: rtl/awx_chk.sv
module awx_chk
  import awx_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [SEL_W-1:0]  wrSel,
  input logic [ADDR_W-1:0] lookAddr,
  input logic              hit,
  input logic [1:0]        winIdx,
  input logic [ADDR_W-1:0] pciAddr,
  input logic [2:0]        cycType,
  input logic              prefetch,
  input logic              lowAdEn
);
  logic sawWrite;

  always_ff @(posedge clk) begin
    if (!rstN) sawWrite <= 1'b0;
    else if (wrEn && wrSel < SEL_W'(2 * NUM_WINS)) sawWrite <= 1'b1;
  end

  // R1
  no_hit_before_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    !sawWrite |-> !hit);

  // R9
  miss_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !hit |-> (winIdx == 2'd0 && pciAddr == '0 && cycType == 3'd0 &&
              !prefetch && !lowAdEn));

  // R6
  low_bits_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hit && !lowAdEn) |-> (pciAddr[1:0] == 2'b00));

  // R6
  low_bits_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hit && lowAdEn) |-> (pciAddr[1:0] == lookAddr[1:0]));

  // R5
  wide_offset_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hit && winIdx < 2'(WIDE_WINS)) |->
      (pciAddr[MIN_SHIFT-1:2] == lookAddr[MIN_SHIFT-1:2]));

  // R7
  io_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hit && winIdx == 2'(WIDE_WINS)) |->
      (cycType == CYC_IO && !prefetch && lowAdEn &&
       pciAddr[IO_SHIFT-1:0] == lookAddr[IO_SHIFT-1:0]));

  // R8
  idx_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    hit |-> (winIdx <= 2'(WIDE_WINS)));
endmodule

bind addr_window_xlate awx_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .wrEn     (wrEn),
  .wrSel    (wrSel),
  .lookAddr (lookAddr),
  .hit      (hit),
  .winIdx   (winIdx),
  .pciAddr  (pciAddr),
  .cycType  (cycType),
  .prefetch (prefetch),
  .lowAdEn  (lowAdEn)
);

// File: tb/addr_window_xlate_tb.sv
module addr_window_xlate_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrSel = '0;
  logic [31:0] wrData = '0;
  logic [31:0] lookAddr = '0;
  logic        hit;
  logic [1:0]  winIdx;
  logic [31:0] pciAddr;
  logic [2:0]  cycType;
  logic        prefetch;
  logic        lowAdEn;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  addr_window_xlate u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .lookAddr(lookAddr), .hit(hit), .winIdx(winIdx), .pciAddr(pciAddr),
    .cycType(cycType), .prefetch(prefetch), .lowAdEn(lowAdEn)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic regWrite(input logic [2:0] sel, input logic [31:0] data);
    @(negedge clk);
    wrEn = 1'b1; wrSel = sel; wrData = data;
    @(posedge clk); #1;
    wrEn = 1'b0;
  endtask

  task automatic expectHit(input string req, input logic [31:0] a,
                           input logic [1:0] idx, input logic [31:0] pa,
                           input logic [2:0] ty, input logic pf,
                           input logic le);
    lookAddr = a; #1;
    chk(hit === 1'b1, req, "hit", {31'd0, hit}, 32'd1);
    chk(winIdx === idx, req, "winIdx", {30'd0, winIdx}, {30'd0, idx});
    chk(pciAddr === pa, req, "pciAddr", pciAddr, pa);
    chk(cycType === ty, req, "cycType", {29'd0, cycType}, {29'd0, ty});
    chk(prefetch === pf, req, "prefetch", {31'd0, prefetch}, {31'd0, pf});
    chk(lowAdEn === le, req, "lowAdEn", {31'd0, lowAdEn}, {31'd0, le});
  endtask

  task automatic expectMiss(input string req, input logic [31:0] a);
    lookAddr = a; #1;
    chk(hit === 1'b0, req, "miss hit", {31'd0, hit}, 32'd0);
    chk({winIdx, cycType, prefetch, lowAdEn} === '0 && pciAddr === '0,
        req, "miss outputs", pciAddr, 32'd0);
  endtask

  task automatic doReset();
    rstN = 1'b0;
    repeat (2) @(posedge clk);
    #1 rstN = 1'b1;
  endtask

  task automatic testReset();
    doReset();
    expectMiss("R1", 32'h4000_0000);
    expectMiss("R1", 32'h0000_0000);
  endtask

  task automatic testBasic();
    doReset();
    regWrite(3'd0, 32'h4000_0081);
    regWrite(3'd1, 32'h0000_0006);
    // R5 R6: 256 MB memory window, low bits forced to 00
    expectHit("R5", 32'h4123_4567, 2'd0, 32'h0123_4564, 3'b011, 1'b0, 1'b0);
    expectMiss("R5", 32'h5000_0000);
    expectMiss("R9", 32'h3FFF_FFFF);
  endtask

  task automatic testSizes();
    doReset();
    regWrite(3'd0, 32'h4000_0001);
    regWrite(3'd1, 32'h0000_ABC7);
    // R3 1 MB window, R6 low bits pass
    expectHit("R3", 32'h400F_FFFF, 2'd0, 32'hABCF_FFFF, 3'b011, 1'b0, 1'b1);
    expectMiss("R3", 32'h4010_0000);
    regWrite(3'd0, 32'h0000_00B1);
    regWrite(3'd1, 32'h0000_8006);
    // R3 2 GB window at size code 11
    expectHit("R3", 32'h7FFF_FFF3, 2'd0, 32'hFFFF_FFF0, 3'b011, 1'b0, 1'b0);
    expectMiss("R3", 32'h8000_0000);
  endtask

  task automatic testBadSize();
    doReset();
    regWrite(3'd1, 32'h0000_0006);
    regWrite(3'd0, 32'h4000_00C1);
    expectMiss("R4", 32'h4000_0000);
    regWrite(3'd0, 32'h4000_00F1);
    expectMiss("R4", 32'h4000_0000);
  endtask

  task automatic testIoWindow();
    doReset();
    regWrite(3'd4, 32'h0000_6001);
    regWrite(3'd5, 32'h0000_1200);
    expectHit("R7", 32'h6012_3457, 2'd2, 32'h1212_3457, 3'b001, 1'b0, 1'b1);
    expectMiss("R7", 32'h6100_0000);
    regWrite(3'd4, 32'h0000_6000);
    expectMiss("R7", 32'h6012_3457);
  endtask

  task automatic testPriority();
    doReset();
    regWrite(3'd0, 32'h4000_0081);
    regWrite(3'd1, 32'h0000_0006);
    regWrite(3'd2, 32'h5000_0089);
    regWrite(3'd3, 32'h0000_100C);
    // R6 memory-multiple cycle type, R3 prefetch bit
    expectHit("R6", 32'h5000_0010, 2'd1, 32'h1000_0010, 3'b110, 1'b1, 1'b0);
    // R8 enlarge window 0 to 512 MB: it hides window 1
    regWrite(3'd0, 32'h4000_0091);
    expectHit("R8", 32'h5000_0010, 2'd0, 32'h1000_0010, 3'b011, 1'b0, 1'b0);
    // remap window 1 to configuration space, 16 MB
    regWrite(3'd2, 32'h6100_0041);
    regWrite(3'd3, 32'h0000_080A);
    regWrite(3'd4, 32'h0000_6101);
    regWrite(3'd5, 32'h0000_3300);
    expectHit("R8", 32'h6100_0104, 2'd1, 32'h0800_0104, 3'b101, 1'b0, 1'b0);
    regWrite(3'd2, 32'h6100_0040);
    expectHit("R8", 32'h6100_0104, 2'd2, 32'h3300_0104, 3'b001, 1'b0, 1'b1);
  endtask

  task automatic testIgnored();
    doReset();
    regWrite(3'd0, 32'h4000_0081);
    regWrite(3'd1, 32'h0000_0006);
    regWrite(3'd6, 32'hFFFF_FFFF);
    regWrite(3'd7, 32'hFFFF_FFFF);
    expectHit("R2", 32'h4000_0100, 2'd0, 32'h0000_0100, 3'b011, 1'b0, 1'b0);
    expectMiss("R2", 32'hF000_0000);
    @(negedge clk);
    wrSel = 3'd0; wrData = 32'h0000_0000;
    @(posedge clk); #1;
    expectHit("R2", 32'h4000_0100, 2'd0, 32'h0000_0100, 3'b011, 1'b0, 1'b0);
  endtask

  task automatic testTiming();
    doReset();
    regWrite(3'd1, 32'h0000_0006);
    @(negedge clk);
    lookAddr = 32'h4000_0200;
    wrEn = 1'b1; wrSel = 3'd0; wrData = 32'h4000_0081;
    #1;
    chk(hit === 1'b0, "R10", "before edge", {31'd0, hit}, 32'd0);
    @(posedge clk); #1;
    wrEn = 1'b0;
    chk(hit === 1'b1, "R10", "after edge", {31'd0, hit}, 32'd1);
    lookAddr = 32'h4000_0300; #1;
    chk(pciAddr === 32'h0000_0300, "R10", "same-cycle lookup",
        pciAddr, 32'h0000_0300);
  endtask

  initial begin
    fork
      begin
        testReset();
        testBasic();
        testSizes();
        testBadSize();
        testIoWindow();
        testPriority();
        testIgnored();
        testTiming();
      end
      begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=expired expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule